// File: doc/BRIEF.md
# Self-Recovering Watchdog Reset Controller

This block supervises a host processor from a free-running clock. A prescaler supplies a one-cycle tick, and the timeout period is a fixed number of those ticks. The host must pull an active-low clear input low at least once per timeout period. When clears stop arriving, the block does not hold the processor in reset. It asserts reset after one timeout and then inverts the reset outputs after every further timeout. The result is a square wave with a period of two timeouts, which gives a hung processor repeated restart attempts.

A digital supply-good flag from an external comparator controls power sequencing. When the flag rises, the block holds reset for exactly one timeout and ignores clears during that time. Watchdog checking starts only after this delay. When the flag falls, reset and the save warning go active at once and override the timer, and clears are locked out until a new power-up completes. The clear input and the supply flag are asynchronous and each passes through a two-flop synchronizer. A low pulse on the clear input is counted only after it has lasted a minimum number of clock cycles.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst` is high, and afterwards until the synchronized supply flag is first seen high, `rst_o`=1, `rst_n_o`=0 and `save_o`=1.
- R2: `clr_n_i` and `supply_ok_i` each pass through a two-flop synchronizer. A change on an input acts on the logic no earlier than two clock edges later.
- R3: In the checking state, each timeout that completes with no clear inverts `rst_o` and `rst_n_o`. With clears missing, the outputs therefore form a square wave whose period is twice the timeout.
- R4: In the checking state, a qualified clear restarts the tick counter from zero and drives `rst_o` to 0 on the next clock edge. This holds whether or not the outputs are toggling.
- R5: After the synchronized supply flag rises, `rst_o` stays 1 until `TIMEOUT_TICKS` ticks have been counted. It then goes to 0 and the checking state begins. Clears during this delay have no effect.
- R6: In the checking state, if `TIMEOUT_TICKS` ticks are counted since the last counter restart with no qualified clear, `rst_o` goes to 1.
- R7: Whenever the synchronized supply flag is low, `rst_o`=1 and `save_o`=1 from the next clock edge on. This overrides the timer, and clears are ignored.
- R8: `rst_n_o` is always the inverse of `rst_o`.
- R9: When the synchronized supply flag is high again, `save_o` goes to 0. The power-on delay then starts from a zero count and the toggle state is discarded.
- R10: A qualified clear is produced once per low period of the synchronized clear signal, on the cycle in which it has been low for `MIN_LOW_CYC` consecutive cycles. Shorter low pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| tick_i | input | 1 | One-cycle prescaler tick, counted toward the timeout |
| clr_n_i | input | 1 | Asynchronous active-low watchdog clear from the host |
| supply_ok_i | input | 1 | Asynchronous supply-good flag, high when the supply is in range |
| rst_o | output | 1 | Active-high reset to the host |
| rst_n_o | output | 1 | Active-low reset to the host, complement of rst_o |
| save_o | output | 1 | Save warning, high while the supply is not good |

## Verification
The bench covers these corner cases, each with the fault it would expose:
- Clear pulses during the power-on delay. A design that honours them would end the delay early.
- A clear that arrives in the middle of the square wave, while reset is active. A design that only restarts the counter would leave reset asserted.
- Clear glitches one cycle shorter than the minimum width, and long held-low clears. A weak filter would reset the watchdog on noise; a level-sensitive one would clear on every cycle of a single pulse.
- A supply drop in the middle of a timeout, followed by a recovery. A design that keeps its counter or toggle phase would time the next power-on delay wrongly.
- A design whose counter is off by one, or that ignores the tick, would shift every edge of the square wave. The cycle-accurate reference in the bench reports that shift.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PWRUP = 2'd1,
        ST_RUN   = 2'd2
    } wdg_state_e;

    typedef struct packed {
        logic rst_act;
        logic save;
    } wdg_out_t;

    localparam wdg_out_t OUT_DOWN = '{rst_act: 1'b1, save: 1'b1};

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int unsigned WIDTH = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, stable_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q   <= RESET_VAL[b];
                stable_q <= RESET_VAL[b];
            end else begin
                meta_q   <= d_i[b];
                stable_q <= meta_q;
            end
        end
        assign q_o[b] = stable_q;
    end
endmodule

// File: rtl/wdg_clr_filter.sv
module wdg_clr_filter #(
    parameter int unsigned MIN_LOW_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n_s,
    output logic clr_evt_o
);
    localparam int unsigned LOW_W = wdg_pkg::cnt_width(MIN_LOW_CYC);
    localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(MIN_LOW_CYC);
    localparam logic [LOW_W-1:0] LOW_HIT = LOW_W'(MIN_LOW_CYC - 1);

    logic [LOW_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst || clr_n_s) begin
            low_q <= '0;
        end else if (low_q != LOW_MAX) begin
            low_q <= low_q + 1'b1;
        end
    end

    assign clr_evt_o = !clr_n_s && (low_q == LOW_HIT);
endmodule

// File: rtl/wdg_tick_timer.sv
module wdg_tick_timer #(
    parameter int unsigned TIMEOUT_TICKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int unsigned CNT_W = wdg_pkg::cnt_width(TIMEOUT_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = tick_i && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 6,
    parameter int unsigned MIN_LOW_CYC   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic clr_n_i,
    input  logic supply_ok_i,
    output logic rst_o,
    output logic rst_n_o,
    output logic save_o
);
    logic [1:0] raw_in, sync_out;
    logic       clr_n_s, sup_s, clr_evt, expire, restart;
    wdg_state_e state_q, state_d;
    wdg_out_t   out_q, out_d;

    assign raw_in = {supply_ok_i, clr_n_i};

    wdg_sync #(.WIDTH(2), .RESET_VAL(2'b01)) i_sync (
        .clk(clk), .rst(rst), .d_i(raw_in), .q_o(sync_out)
    );

    assign clr_n_s = sync_out[0];
    assign sup_s   = sync_out[1];

    wdg_clr_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) i_filter (
        .clk(clk), .rst(rst), .clr_n_s(clr_n_s), .clr_evt_o(clr_evt)
    );

    wdg_tick_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) i_timer (
        .clk(clk), .rst(rst), .restart_i(restart),
        .tick_i(tick_i), .expire_o(expire)
    );

    // Counter restarts while powered down, on leaving power-down, or on a
    // qualified clear during checking.
    assign restart = !sup_s || (state_q == ST_OFF) ||
                     ((state_q == ST_RUN) && clr_evt);

    always_comb begin
        state_d = state_q;
        out_d   = out_q;
        if (!sup_s) begin
            state_d = ST_OFF;
            out_d   = OUT_DOWN;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d       = ST_PWRUP;
                    out_d.rst_act = 1'b1;
                    out_d.save    = 1'b0;
                end
                ST_PWRUP: begin
                    if (expire) begin
                        state_d       = ST_RUN;
                        out_d.rst_act = 1'b0;
                    end
                end
                ST_RUN: begin
                    if (clr_evt) begin
                        out_d.rst_act = 1'b0;
                    end else if (expire) begin
                        out_d.rst_act = !out_q.rst_act;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    out_d   = OUT_DOWN;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            out_q   <= OUT_DOWN;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    assign rst_o   = out_q.rst_act;
    assign rst_n_o = !out_q.rst_act;
    assign save_o  = out_q.save;
endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk
    import wdg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sup_s,
    input logic       clr_evt,
    input logic       expire,
    input wdg_state_e state_q,
    input logic       rst_o,
    input logic       rst_n_o,
    input logic       save_o
);
    assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
        rst_o != rst_n_o);

    assert_drop_override_R7: assert property (@(posedge clk) disable iff (rst)
        !sup_s |=> (rst_o && save_o));

    assert_save_release_R9: assert property (@(posedge clk) disable iff (rst)
        sup_s |=> !save_o);

    assert_pwrup_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PWRUP && sup_s && !expire) |=> rst_o);

    assert_clear_release_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && sup_s && clr_evt) |=> !rst_o);

    assert_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && sup_s && !clr_evt && expire) |=> (rst_o != $past(rst_o)));
endmodule

bind wdg_supervisor wdg_supervisor_chk i_chk (
    .clk(clk), .rst(rst), .sup_s(sup_s), .clr_evt(clr_evt), .expire(expire),
    .state_q(state_q), .rst_o(rst_o), .rst_n_o(rst_n_o), .save_o(save_o)
);

// File: tb/test_wdg_supervisor.sv
module test_wdg_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int TO   = 6;
    localparam int MINL = 3;
    localparam int WATCHDOG_CYC = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b0;
    logic clr_n_i = 1'b1;
    logic supply_ok_i = 1'b0;
    logic rst_o, rst_n_o, save_o;

    int vectors = 0;
    int miscompares = 0;
    string phase = "R1 reset";

    // Reference state, from the requirements.
    logic m_c1, m_c2, m_s1, m_s2, m_rst, m_save;
    int   m_low, m_cnt, m_st;  // 0 off, 1 power-up, 2 checking

    always #(CLK_PERIOD/2) clk = !clk;

    wdg_supervisor #(.TIMEOUT_TICKS(TO), .MIN_LOW_CYC(MINL)) i_wdg_supervisor (
        .clk(clk), .rst(rst), .tick_i(tick_i), .clr_n_i(clr_n_i),
        .supply_ok_i(supply_ok_i), .rst_o(rst_o), .rst_n_o(rst_n_o), .save_o(save_o)
    );

    function automatic bit qual_clear(logic c2, int low);
        return !c2 && (low == MINL - 1);   // R10
    endfunction

    function automatic bit timeout_hit(logic tk, int cnt);
        return tk && (cnt == TO - 1);      // R5, R6
    endfunction

    always @(posedge clk) begin
        bit evt, exp_t, rs;
        if (rst) begin
            m_c1 = 1; m_c2 = 1; m_s1 = 0; m_s2 = 0;
            m_rst = 1; m_save = 1; m_low = 0; m_cnt = 0; m_st = 0;
        end else begin
            evt   = qual_clear(m_c2, m_low);
            exp_t = timeout_hit(tick_i, m_cnt);
            rs    = !m_s2 || m_st == 0 || (m_st == 2 && evt);
            if (!m_s2) begin
                m_st = 0; m_rst = 1; m_save = 1;
            end else if (m_st == 0) begin
                m_st = 1; m_rst = 1; m_save = 0;
            end else if (m_st == 1) begin
                if (exp_t) begin m_st = 2; m_rst = 0; end
            end else begin
                if (evt) m_rst = 0;
                else if (exp_t) m_rst = !m_rst;
            end
            if (rs) m_cnt = 0;
            else if (tick_i) m_cnt = exp_t ? 0 : m_cnt + 1;
            if (m_c2) m_low = 0;
            else if (m_low != MINL) m_low = m_low + 1;
            m_c2 = m_c1; m_c1 = clr_n_i;
            m_s2 = m_s1; m_s1 = supply_ok_i;
        end
    end

    task automatic check(string tag, logic act, logic exp_v);
        vectors++;
        if (act !== exp_v) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp_v);
        end
    endtask

    task automatic compare_all();
        check({phase, " rst_o"}, rst_o, m_rst);
        check({"R8 ", phase, " rst_n_o"}, rst_n_o, !m_rst);
        check({phase, " save_o"}, save_o, m_save);
    endtask

    task automatic step(logic c, logic s, logic t, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            clr_n_i = c; supply_ok_i = s; tick_i = t;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: explicit reset-state check, then stays down while supply low
        check("R1 reset rst_o", rst_o, 1'b1);
        check("R1 reset rst_n_o", rst_n_o, 1'b0);
        check("R1 reset save_o", save_o, 1'b1);
        phase = "R1 down";
        step(1, 0, 1, 10);
        // R5: power-up delay, clears inside it ignored
        phase = "R5 power-up";
        step(1, 1, 1, 3);
        step(0, 1, 1, 5);
        step(1, 1, 1, 12);
        // R6/R3: no clears, square wave
        phase = "R3 R6 toggling";
        step(1, 1, 1, 40);
        // R4: clear in the middle of the square wave
        phase = "R4 clear";
        step(0, 1, 1, 6);
        step(1, 1, 1, 4);
        // R10: glitches shorter than the minimum width
        phase = "R10 glitch";
        for (int k = 0; k < 6; k++) begin
            step(0, 1, 1, MINL - 1);
            step(1, 1, 1, 3);
        end
        // R10: a long low is one clear only
        phase = "R10 long low";
        step(0, 1, 1, 30);
        step(1, 1, 0, 5);
        // R7: supply drop mid-timeout, clears ignored
        phase = "R7 drop";
        step(1, 1, 1, 3);
        step(1, 0, 1, 4);
        step(0, 0, 1, 6);
        step(1, 0, 0, 3);
        // R9: recovery restarts the power-on delay from zero
        phase = "R9 recover";
        step(1, 1, 1, 25);
        // R2: random mix
        phase = "R2 random";
        for (int k = 0; k < 2500; k++) begin
            logic c, s, t;
            c = ($urandom % 8) != 0;
            s = ($urandom % 200) != 0 || (k < 50);
            t = ($urandom % 3) != 0;
            step(c, s, t, 1 + ($urandom % 3));
        end
        @(negedge clk);
        compare_all();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule